// File: doc/BRIEF.md
# DMA Channel Fault Monitor

This block sits beside one DMA channel and watches five things: writes to the channel's control registers, the addresses the channel produces, its trigger input, the error response from memory and the strobe from the bandwidth monitor. When one of these shows an illegal condition, the block stores a 3-bit cause code with a valid flag. It also asks the channel to halt, except for a bandwidth fault, which only reports. It can raise an interrupt as well.

Register writes are screened in the same cycle. If the channel is enabled and running, a write to a configuration register is suppressed through a block signal. Writes to the status register and the two bandwidth count registers always go through. A write to a read-only location, or to an address outside the map, gets a bus error back on the control interface. Such a write does not touch the cause code. Software clears the stored cause by writing 1 to bit 0 of the status register.

Top module: `dma_err_unit`

## Requirements
- R1: The register map uses word addresses: 0 config, 1 start address, 2 count, 3 stride, 4 descriptor pointer, 5 status, 6 bandwidth limit, 7 bandwidth count, 8 and 9 channel-state registers. Addresses 10 to 15 are unmapped. A write to a mapped address, with the read-only flag low, while enable and run are both high, raises `wr_block_o` in the same cycle and latches code 1 (illegal write). The exceptions are addresses 5, 6 and 7.
- R2: Writes to addresses 5, 6 and 7 never raise `wr_block_o` and never latch a code, even while the channel runs.
- R3: A descriptor fetch address whose two low bits are not zero latches code 2 (alignment).
- R4: A transfer start address that is not a multiple of 2^msize bytes latches code 2. msize 0 to 5 select 1 to 32 bytes. msize 6 and 7 are treated as 32 bytes.
- R5: A memory error response latches code 3 (memory access).
- R6: A trigger pulse that arrives while an earlier trigger is pending latches code 4 (trigger overrun), but only when the overrun-enable input is 1. A work-unit start accepts the pending trigger and clears it. A trigger in the same cycle as a work-unit start is not an overrun.
- R7: A bandwidth expiry strobe latches code 5. It never asserts `halt_o`.
- R8: A write with the read-only flag set, or to an unmapped address, raises `bus_err_o` in the same cycle. It does not block the write as illegal and does not latch a code.
- R9: A work-unit start on a receive channel with synchronized mode latches code 6 (configuration) when it is not the first work unit and its peripheral size differs from that of the previous work unit.
- R10: When several faults occur in one cycle, the code of the highest-priority one is latched. The order from highest to lowest is memory access, alignment, configuration, illegal write, trigger overrun, bandwidth.
- R11: The code and valid flag appear one cycle after the fault and stay unchanged until a write to address 5 with data bit 0 set. A write with bit 0 clear does not clear them. If a fault occurs in the clearing cycle, its code is latched instead. While not valid, the code reads 0.
- R12: Every fault except bandwidth asserts `halt_o` for exactly the one cycle after it occurs. This holds whether or not a code is already stored.
- R13: `irq_o` pulses for one cycle, together with the valid flag, when a code is newly latched and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_ro_i | input | 1 | Addressed register is read-only |
| ch_en_i | input | 1 | Channel enabled |
| ch_run_i | input | 1 | Channel running |
| dsc_fetch_i | input | 1 | Descriptor fetch issued |
| dsc_addr_i | input | 32 | Descriptor fetch address |
| xfer_start_i | input | 1 | Transfer start issued |
| xfer_addr_i | input | 32 | Transfer start address |
| msize_i | input | 3 | Memory word-size code |
| mem_err_i | input | 1 | Memory error response |
| trig_i | input | 1 | Trigger input pulse |
| tov_en_i | input | 1 | Trigger overrun check enable |
| wu_start_i | input | 1 | Work unit start (accepts trigger) |
| wu_first_i | input | 1 | Starting work unit is the first |
| rx_i | input | 1 | Channel writes memory (receive) |
| sync_i | input | 1 | Synchronized mode |
| psize_i | input | 3 | Peripheral size of starting work unit |
| bw_expire_i | input | 1 | Bandwidth monitor expiry strobe |
| irq_en_i | input | 1 | Error interrupt enable |
| wr_block_o | output | 1 | Suppress current register write |
| bus_err_o | output | 1 | Bus error response for current access |
| err_valid_o | output | 1 | Stored cause is valid |
| err_code_o | output | 3 | Stored cause code |
| halt_o | output | 1 | Fatal halt request pulse |
| irq_o | output | 1 | Error interrupt pulse |

## Verification
The bench looks for these corner cases:
- The exempt addresses while the channel runs. A design that used a plain "running" gate would block them and report an illegal write.
- A clear write carrying data bit 0 low, and a clear that coincides with a new fault. A wrong design would either lose the stored cause or drop the new one.
- Every msize value, including the reserved codes 6 and 7, with addresses that are misaligned by exactly half the access size. This catches off-by-one mask errors.
- A trigger that coincides with a work-unit start, and coincident faults of mixed priority. These expose wrong overrun detection and wrong ordering.
- A bandwidth fault. Here a design that halts would fail the check on the halt output.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ILLWR = 3'd1,
    ERR_ALIGN = 3'd2,
    ERR_MEM   = 3'd3,
    ERR_TOV   = 3'd4,
    ERR_BW    = 3'd5,
    ERR_CFG   = 3'd6
  } err_code_e;

  // fault vector index = priority (0 highest)
  localparam int unsigned F_MEM     = 0;
  localparam int unsigned F_ALIGN   = 1;
  localparam int unsigned F_CFG     = 2;
  localparam int unsigned F_ILLWR   = 3;
  localparam int unsigned F_TOV     = 4;
  localparam int unsigned F_BW      = 5;
  localparam int unsigned NUM_FAULT = 6;

  // register word addresses
  localparam int unsigned RA_STAT  = 5;
  localparam int unsigned RA_BWLIM = 6;
  localparam int unsigned RA_BWCNT = 7;
  localparam int unsigned RA_LAST  = 9;
  localparam int unsigned STAT_CLR_BIT = 0;

  function automatic err_code_e fault_code(input int unsigned idx);
    case (idx)
      F_MEM:   return ERR_MEM;
      F_ALIGN: return ERR_ALIGN;
      F_CFG:   return ERR_CFG;
      F_ILLWR: return ERR_ILLWR;
      F_TOV:   return ERR_TOV;
      F_BW:    return ERR_BW;
      default: return ERR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_err_regchk.sv
module dma_err_regchk
  import dma_err_pkg::*;
#(
  parameter int unsigned RAW = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_wr_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  input  logic           reg_ro_i,
  input  logic           ch_en_i,
  input  logic           ch_run_i,
  output logic           wr_block_o,
  output logic           bus_err_o,
  output logic           illwr_o,
  output logic           clr_o
);

  localparam logic [RAW-1:0] A_STAT  = RAW'(RA_STAT);
  localparam logic [RAW-1:0] A_BWLIM = RAW'(RA_BWLIM);
  localparam logic [RAW-1:0] A_BWCNT = RAW'(RA_BWCNT);
  localparam logic [RAW-1:0] A_LAST  = RAW'(RA_LAST);

  logic mapped, exempt, wr_ok, busy;

  always_comb begin
    mapped = (reg_addr_i <= A_LAST);
    exempt = (reg_addr_i == A_STAT) || (reg_addr_i == A_BWLIM) ||
             (reg_addr_i == A_BWCNT);
    busy   = ch_en_i && ch_run_i;
    wr_ok  = reg_wr_i && mapped && !reg_ro_i;
    bus_err_o  = reg_wr_i && (!mapped || reg_ro_i);
    illwr_o    = wr_ok && busy && !exempt;
    wr_block_o = illwr_o;
    clr_o      = wr_ok && (reg_addr_i == A_STAT) && reg_wdata_i[STAT_CLR_BIT];
  end

  AST_EXEMPT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == A_STAT || reg_addr_i == A_BWLIM || reg_addr_i == A_BWCNT))
      |-> !wr_block_o); // R2
  AST_BLOCK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |-> (ch_en_i && ch_run_i)); // R1
  AST_BUSERR_NOT_ILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !illwr_o && !clr_o); // R8

endmodule

// File: rtl/dma_err_align.sv
module dma_err_align #(
  parameter int unsigned AW       = 32,
  parameter int unsigned SW       = 3,
  parameter int unsigned SIZE_MAX = 5,
  parameter int unsigned DSC_LOG  = 2
) (
  input  logic          dsc_fetch_i,
  input  logic [AW-1:0] dsc_addr_i,
  input  logic          xfer_start_i,
  input  logic [AW-1:0] xfer_addr_i,
  input  logic [SW-1:0] msize_i,
  output logic          fault_o
);

  logic [SIZE_MAX-1:0] mask;
  logic [SW-1:0]       eff;
  logic                dsc_bad, xfer_bad;

  always_comb begin
    eff = (msize_i > SW'(SIZE_MAX)) ? SW'(SIZE_MAX) : msize_i;
  end

  for (genvar g = 0; g < SIZE_MAX; g++) begin : g_mask
    assign mask[g] = (SW'(g) < eff);
  end

  always_comb begin
    dsc_bad  = dsc_fetch_i && (dsc_addr_i[DSC_LOG-1:0] != '0);
    xfer_bad = xfer_start_i && ((xfer_addr_i[SIZE_MAX-1:0] & mask) != '0);
    fault_o  = dsc_bad || xfer_bad;
  end

endmodule

// File: rtl/dma_err_seq.sv
module dma_err_seq #(
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          tov_en_i,
  input  logic          wu_start_i,
  input  logic          wu_first_i,
  input  logic          rx_i,
  input  logic          sync_i,
  input  logic [PW-1:0] psize_i,
  output logic          tov_fault_o,
  output logic          cfg_fault_o
);

  logic          pend_q;
  logic [PW-1:0] psize_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      psize_q <= '0;
    end else begin
      pend_q <= trig_i || (pend_q && !wu_start_i);
      if (wu_start_i) psize_q <= psize_i;
    end
  end

  always_comb begin
    tov_fault_o = tov_en_i && trig_i && pend_q && !wu_start_i;
    cfg_fault_o = wu_start_i && !wu_first_i && rx_i && sync_i && (psize_i != psize_q);
  end

  AST_TOV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tov_en_i |-> !tov_fault_o); // R6
  AST_TRIG_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pend_q); // R6
  AST_CFG_NOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wu_first_i |-> !cfg_fault_o); // R9

endmodule

// File: rtl/dma_err_latch.sv
module dma_err_latch
  import dma_err_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FAULT-1:0] fault_i,
  input  logic                 clr_i,
  input  logic                 irq_en_i,
  output logic                 valid_o,
  output err_code_e            code_o,
  output logic                 halt_o,
  output logic                 irq_o
);

  err_code_e sel;
  logic      any, fatal, take;
  logic      valid_q, halt_q, irq_q;
  err_code_e code_q;

  always_comb begin
    sel = ERR_NONE;
    for (int i = NUM_FAULT - 1; i >= 0; i--) begin
      if (fault_i[i]) sel = fault_code(i);
    end
    any   = |fault_i;
    fatal = |(fault_i & ~(NUM_FAULT'(1) << F_BW));
    take  = any && (!valid_q || clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= ERR_NONE;
      halt_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        code_q  <= sel;
      end else if (clr_i) begin
        valid_q <= 1'b0;
        code_q  <= ERR_NONE;
      end
      halt_q <= fatal;
      irq_q  <= take && irq_en_i;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
  assign halt_o  = halt_q;
  assign irq_o   = irq_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_i) |=> (valid_q && $stable(code_q))); // R11
  AST_BW_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i == (NUM_FAULT'(1) << F_BW)) |=> !halt_q); // R7
  AST_HALT_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> valid_q); // R12
  AST_IRQ_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> valid_q); // R13
  AST_NONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (code_q == ERR_NONE)); // R11

endmodule

// File: rtl/dma_err_unit.sv
module dma_err_unit
  import dma_err_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned RAW = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned SW  = 3,
  parameter int unsigned PW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_wr_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  input  logic           reg_ro_i,
  input  logic           ch_en_i,
  input  logic           ch_run_i,
  input  logic           dsc_fetch_i,
  input  logic [AW-1:0]  dsc_addr_i,
  input  logic           xfer_start_i,
  input  logic [AW-1:0]  xfer_addr_i,
  input  logic [SW-1:0]  msize_i,
  input  logic           mem_err_i,
  input  logic           trig_i,
  input  logic           tov_en_i,
  input  logic           wu_start_i,
  input  logic           wu_first_i,
  input  logic           rx_i,
  input  logic           sync_i,
  input  logic [PW-1:0]  psize_i,
  input  logic           bw_expire_i,
  input  logic           irq_en_i,
  output logic           wr_block_o,
  output logic           bus_err_o,
  output logic           err_valid_o,
  output logic [2:0]     err_code_o,
  output logic           halt_o,
  output logic           irq_o
);

  logic                 illwr, clr, align_f, tov_f, cfg_f;
  logic [NUM_FAULT-1:0] fault;
  err_code_e            code;

  dma_err_regchk #(.RAW(RAW), .DW(DW)) u_regchk (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_ro_i,
    .ch_en_i, .ch_run_i, .wr_block_o, .bus_err_o,
    .illwr_o(illwr), .clr_o(clr)
  );

  dma_err_align #(.AW(AW), .SW(SW)) u_align (
    .dsc_fetch_i, .dsc_addr_i, .xfer_start_i, .xfer_addr_i, .msize_i,
    .fault_o(align_f)
  );

  dma_err_seq #(.PW(PW)) u_seq (
    .clk_i, .rst_ni, .trig_i, .tov_en_i, .wu_start_i, .wu_first_i,
    .rx_i, .sync_i, .psize_i,
    .tov_fault_o(tov_f), .cfg_fault_o(cfg_f)
  );

  always_comb begin
    fault          = '0;
    fault[F_MEM]   = mem_err_i;
    fault[F_ALIGN] = align_f;
    fault[F_CFG]   = cfg_f;
    fault[F_ILLWR] = illwr;
    fault[F_TOV]   = tov_f;
    fault[F_BW]    = bw_expire_i;
  end

  dma_err_latch u_latch (
    .clk_i, .rst_ni, .fault_i(fault), .clr_i(clr), .irq_en_i,
    .valid_o(err_valid_o), .code_o(code), .halt_o, .irq_o
  );

  assign err_code_o = code;

  AST_MEM_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_err_i && (!err_valid_o || clr)) |=> (err_code_o == 3'd3)); // R10
  AST_MEM_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_err_i |=> halt_o); // R12
  AST_BUSERR_NO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o && !err_valid_o && !(|fault)) |=> !err_valid_o); // R8

endmodule

// File: tb/sim_dma_err_unit.sv
`timescale 1ns/1ps
module sim_dma_err_unit;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 0, ro = 0, en = 0, run = 0, dsc = 0, xs = 0, mem = 0;
  logic        trig = 0, tov_en = 0, wu = 0, first = 0, rx = 0, sync = 0, bw = 0, ie = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, daddr = '0, xaddr = '0;
  logic [2:0]  msize = '0, psize = '0;
  logic        wr_block, bus_err, valid, halt, irq;
  logic [2:0]  code;

  int n_chk = 0, n_err = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  dma_err_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_ro_i(ro), .ch_en_i(en), .ch_run_i(run), .dsc_fetch_i(dsc), .dsc_addr_i(daddr),
    .xfer_start_i(xs), .xfer_addr_i(xaddr), .msize_i(msize), .mem_err_i(mem),
    .trig_i(trig), .tov_en_i(tov_en), .wu_start_i(wu), .wu_first_i(first), .rx_i(rx),
    .sync_i(sync), .psize_i(psize), .bw_expire_i(bw), .irq_en_i(ie),
    .wr_block_o(wr_block), .bus_err_o(bus_err), .err_valid_o(valid), .err_code_o(code),
    .halt_o(halt), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_valid = 0, m_code = 0, m_halt = 0, m_irq = 0, m_pend = 0, m_lastp = 0;

  function automatic bit is_mapped(int a); return a <= 9; endfunction
  function automatic bit is_exempt(int a); return a == 5 || a == 6 || a == 7; endfunction
  function automatic int exp_block();
    return wr && is_mapped(addr) && !ro && en && run && !is_exempt(addr);
  endfunction
  function automatic int exp_bus();
    return wr && (!is_mapped(addr) || ro);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int c, sz, clr_now;
    bit f_mem, f_al, f_cfg, f_ill, f_tov, f_bw;
    if (!rst_n) begin
      m_valid = 0; m_code = 0; m_halt = 0; m_irq = 0; m_pend = 0; m_lastp = 0;
    end else begin
      sz = (msize > 5) ? 32 : (1 << msize);
      f_mem = mem;
      f_al  = (dsc && (daddr % 4 != 0)) || (xs && (xaddr % sz != 0));
      f_cfg = wu && !first && rx && sync && (psize != m_lastp);
      f_ill = exp_block();
      f_tov = tov_en && trig && m_pend && !wu;
      f_bw  = bw;
      clr_now = wr && is_mapped(addr) && !ro && addr == 5 && wdata[0];
      if (f_mem) c = 3; else if (f_al) c = 2; else if (f_cfg) c = 6;
      else if (f_ill) c = 1; else if (f_tov) c = 4; else if (f_bw) c = 5; else c = 0;
      m_halt = f_mem || f_al || f_cfg || f_ill || f_tov;
      m_irq  = 0;
      if (c != 0 && (!m_valid || clr_now)) begin
        m_valid = 1; m_code = c; m_irq = ie;
      end else if (clr_now) begin
        m_valid = 0; m_code = 0;
      end
      m_pend = trig || (m_pend && !wu);
      if (wu) m_lastp = psize;
    end
  end

  always @(negedge clk) if (live) begin
    chk("R1 wr_block", wr_block, exp_block());
    chk("R8 bus_err", bus_err, exp_bus());
    chk("R11 valid", valid, m_valid);
    chk("R10 code", code, m_code);
    chk("R12 halt", halt, m_halt);
    chk("R13 irq", irq, m_irq);
  end

  task automatic tick();
    @(posedge clk); #1;
    wr = 0; ro = 0; dsc = 0; xs = 0; mem = 0; trig = 0; wu = 0; first = 0; bw = 0;
  endtask

  task automatic wreg(input int a, input int d);
    wr = 1; addr = 4'(a); wdata = 32'(d);
  endtask

  task automatic clear();
    wreg(5, 1); tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    live = 1;
    chk("R11 reset valid", valid, 0);
    chk("R12 reset halt", halt, 0);
    rst_n = 1; ie = 1;
    tick();

    // R1 illegal write
    en = 1; run = 0; wreg(0, 32'h55); tick();
    chk("R1 idle write allowed", valid, 0);
    run = 1; wreg(0, 32'h55); #1;
    chk("R1 block while running", wr_block, 1);
    tick();
    chk("R1 code", code, 1);
    chk("R12 halt pulse", halt, 1);
    chk("R13 irq pulse", irq, 1);
    tick();
    chk("R12 halt one cycle", halt, 0);
    chk("R13 irq one cycle", irq, 0);

    // R11 clear semantics
    wreg(5, 0); tick();
    chk("R11 clear needs bit0", valid, 1);
    clear();
    chk("R11 cleared", valid, 0);

    // R2 exempt registers
    for (int a = 5; a <= 7; a++) begin
      wreg(a, 2); #1;
      chk("R2 exempt not blocked", wr_block, 0);
      tick();
    end
    chk("R2 exempt no code", valid, 0);

    // R8 bus errors
    wreg(8, 1); ro = 1; #1;
    chk("R8 ro bus err", bus_err, 1);
    chk("R8 ro not blocked", wr_block, 0);
    tick();
    wreg(12, 1); #1;
    chk("R8 unmapped bus err", bus_err, 1);
    tick();
    chk("R8 no code", valid, 0);

    // R3 descriptor alignment
    dsc = 1; daddr = 32'h1004; tick();
    chk("R3 aligned ok", valid, 0);
    dsc = 1; daddr = 32'h1002; tick();
    chk("R3 misaligned", code, 2);
    clear();

    // R4 transfer alignment per msize
    for (int m = 0; m < 8; m++) begin
      int sz;
      sz = (m > 5) ? 32 : (1 << m);
      msize = 3'(m); xs = 1; xaddr = 32'h4000 + 32'(sz * 3); tick();
      chk("R4 aligned ok", valid, 0);
      if (sz > 1) begin
        xs = 1; xaddr = 32'h4000 + 32'(sz / 2); tick();
        chk("R4 misaligned", code, 2);
        clear();
      end
    end
    msize = 0;

    // R5 memory error
    mem = 1; tick();
    chk("R5 mem code", code, 3);
    chk("R12 mem halt", halt, 1);
    clear();

    // R6 trigger overrun
    tov_en = 0; trig = 1; tick(); trig = 1; tick();
    chk("R6 disabled no overrun", valid, 0);
    tov_en = 1; trig = 1; tick();
    chk("R6 overrun", code, 4);
    clear();
    wu = 1; tick();
    trig = 1; tick();
    chk("R6 accepted no overrun", valid, 0);
    trig = 1; wu = 1; tick();
    chk("R6 with wu start no overrun", valid, 0);
    trig = 1; tick();
    chk("R6 overrun after refill", code, 4);
    clear();

    // R7 bandwidth
    bw = 1; tick();
    chk("R7 bw code", code, 5);
    chk("R7 bw no halt", halt, 0);
    clear();

    // R9 psize change
    rx = 1; sync = 1;
    wu = 1; first = 1; psize = 2; tick();
    chk("R9 first ok", valid, 0);
    wu = 1; psize = 2; tick();
    chk("R9 same size ok", valid, 0);
    wu = 1; psize = 3; tick();
    chk("R9 size change", code, 6);
    clear();
    rx = 0; wu = 1; psize = 1; tick();
    chk("R9 tx ignored", valid, 0);

    // R10 priority
    mem = 1; dsc = 1; daddr = 32'h3; bw = 1; tick();
    chk("R10 mem over align", code, 3);
    clear();
    rx = 1; wu = 1; psize = 2; dsc = 1; daddr = 32'h1; tick();
    chk("R10 align over cfg", code, 2);
    clear();
    rx = 0;
    trig = 1; tick();
    trig = 1; wreg(1, 7); tick();
    chk("R10 illwr over tov", code, 1);
    clear();
    trig = 1; bw = 1; tick();
    chk("R10 tov over bw", code, 4);

    // R11 new fault during clear
    wreg(5, 1); bw = 1; tick();
    chk("R11 fault in clear cycle", code, 5);
    clear();

    // R13 interrupt disabled
    ie = 0; mem = 1; tick();
    chk("R13 no irq when disabled", irq, 0);
    chk("R5 still latched", code, 3);
    ie = 1; clear();
    repeat (3) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule